// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits beside a sector-programmed nonvolatile array and watches every byte load on the parallel host bus. It decides whether the timed program cycle that follows a load window writes real data or is only a dummy timed cycle. A host enables software protection with a three-write unlock prefix. Once protection is on, that same prefix has to open every later program window. Longer command sequences turn protection off, erase the whole array, or permanently lock one of two 16 KB boot regions. One region is at the bottom of the address space and the other at the top.

Writes are refused until the supply has been good for a set number of clocks. A write strobe only counts when it is held for a minimum number of stable clocks with output enable high. Command sequences can also place the block in an identification mode. In that mode, reads at two fixed addresses report the lockout state of each region. The protection flag and both lockout flags start cleared. After that they are changed only by commands. The synchronous reset clears the sequencer, the window, the busy timer and identification mode, but not these flags.

Top module: `wp_cmd_sequencer`

## Requirements
- R1: A byte load is accepted only after `supply_good` has been high for more than `PWR_DLY` consecutive clocks. Any low cycle restarts that count. A reset also restarts it.
- R2: A write strobe is active when `chip_sel_n`=0, `wr_en_n`=0 and `out_en_n`=1. It yields a byte load only if it stays active for at least `MIN_PULSE` consecutive clocks. Shorter strobes, and strobes made while `out_en_n`=0, load nothing.
- R3: A load takes its address from the first active clock of the strobe and its data from the last active clock.
- R4: A load window opens at the first load. It closes `LOAD_GAP` clocks after the last load. If the window held any data byte, exactly one of `prog_go` or `prog_reject` pulses for one clock.
- R5: Protection is off after configuration. The sequence AAh@5555h, 55h@2AAAh, A0h@5555h turns protection on. It also lets the rest of that window through as data, so the window ends in `prog_go`. Protection survives `rst`.
- R6: With protection on, a window of data without the prefix ends in `prog_reject`. Any data window starts a timed cycle in which `busy` is high for exactly `PROG_CYC` clocks.
- R7: The six-write sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h turns protection off. Data loads after it in the same window are let through.
- R8: A byte that breaks a command sequence returns the recogniser to idle and counts as an ordinary data byte. Once a window holds data, no later byte in it is decoded as a command.
- R9: The same five-write head followed by 40h@5555h, then a seventh write at any address, sets a permanent lock. The lock applies to the low region (address below 4000h) or to the high region (address at or above 7C000h), whichever holds the seventh address. A data window touching a locked region ends in `prog_reject`.
- R10: The five-write head followed by 10h@5555h is a chip erase. It pulses `erase_go` if neither region is locked and `erase_reject` otherwise, and starts a timed cycle either way.
- R11: AAh@5555h, 55h@2AAAh, 90h@5555h enters identification mode, and the same head with F0h leaves it. In the mode, a read (`chip_sel_n`=0, `out_en_n`=0, `wr_en_n`=1) returns FFh if the region is locked and FEh if not. Address 00002h reports the low region and 7FFF2h the high region; any other address returns 00h. The result shows on `id_data`, with `id_valid`, one clock later. Outside the mode `id_valid` stays 0.
- R12: Byte loads that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (keeps protection and lock flags) |
| supply_good | input | 1 | Supply above the write threshold |
| chip_sel_n | input | 1 | Bus select, active low |
| out_en_n | input | 1 | Bus read enable, active low |
| wr_en_n | input | 1 | Bus write strobe, active low |
| addr | input | AW | Bus byte address |
| wdata | input | 8 | Bus write data |
| prog_go | output | 1 | One-clock pulse: the window's data is programmed |
| prog_reject | output | 1 | One-clock pulse: the window runs a dummy timed cycle |
| erase_go | output | 1 | One-clock pulse: chip erase accepted |
| erase_reject | output | 1 | One-clock pulse: chip erase refused |
| busy | output | 1 | Timed cycle in progress |
| prot_on | output | 1 | Software protection enabled |
| lock_lo | output | 1 | Low boot region locked |
| lock_hi | output | 1 | High boot region locked |
| id_mode | output | 1 | Identification mode active |
| id_valid | output | 1 | `id_data` holds an identification read result |
| id_data | output | 8 | Identification read data |

## Verification
The bench probes the strobe filter exactly at `MIN_PULSE`-1 and `MIN_PULSE` clocks. A filter off by one would either program from a glitch or drop a legal load. It moves the address in the middle of a command strobe. A design that latched the address late would miss the identification entry that follows. It sends broken command sequences with protection both on and off, and pulses reset with protection on. A recogniser that swallowed the breaking byte, or a reset that cleared protection, would give the wrong go/reject outcome. It also locks each boot region in turn and checks the identification values, erase refusal, per-region rejection, and that a load during a timed cycle starts no second cycle.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_K1,
    SQ_K2,
    SQ_X0,
    SQ_X1,
    SQ_X2,
    SQ_LK
  } wp_seq_e;

  typedef enum logic [3:0] {
    EV_NONE,
    EV_DATA,
    EV_CMD,
    EV_UNLOCK,
    EV_DISABLE,
    EV_ID_ON,
    EV_ID_OFF,
    EV_ERASE,
    EV_LOCK
  } wp_evt_e;

endpackage

// File: rtl/wp_strobe_filter.sv
module wp_strobe_filter #(
  parameter int AW        = 19,
  parameter int MIN_PULSE = 3,
  parameter int PWR_DLY   = 250000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_good,
  input  logic          chip_sel_n,
  input  logic          out_en_n,
  input  logic          wr_en_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          ld_vld,
  output logic [AW-1:0] ld_addr,
  output logic [7:0]    ld_data
);
  localparam int PW = $clog2(PWR_DLY + 1);
  localparam int RW = $clog2(MIN_PULSE + 1);
  localparam logic [PW-1:0] PWR_LIM = PW'(PWR_DLY);
  localparam logic [RW-1:0] RUN_LIM = RW'(MIN_PULSE);

  logic [PW-1:0] pwr_cnt;
  logic          ready_q;
  logic          wr_act;
  logic          act_q;
  logic [RW-1:0] run_cnt;
  logic [AW-1:0] cap_addr;
  logic [7:0]    cap_data;

  assign wr_act = !chip_sel_n && !wr_en_n && out_en_n;

  // power-up hold-off: counts clean supply cycles
  always_ff @(posedge clk) begin
    if (rst || !supply_good) begin
      pwr_cnt <= '0;
      ready_q <= 1'b0;
    end else if (pwr_cnt == PWR_LIM) begin
      ready_q <= 1'b1;
    end else begin
      pwr_cnt <= pwr_cnt + 1'b1;
    end
  end

  // pulse qualification: address at first active clock, data at last
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      run_cnt  <= '0;
      ld_vld   <= 1'b0;
      ld_addr  <= '0;
      ld_data  <= '0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      act_q  <= wr_act;
      ld_vld <= 1'b0;
      if (wr_act) begin
        if (!act_q) cap_addr <= addr;
        cap_data <= wdata;
        if (run_cnt != RUN_LIM) run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= '0;
        if (act_q && run_cnt == RUN_LIM && ready_q) begin
          ld_vld  <= 1'b1;
          ld_addr <= cap_addr;
          ld_data <= cap_data;
        end
      end
    end
  end
endmodule

// File: rtl/wp_cmd_recog.sv
module wp_cmd_recog
  import wp_pkg::*;
#(
  parameter int             AW        = 19,
  parameter logic [AW-1:0]  CMD_A1    = 'h5555,
  parameter logic [AW-1:0]  CMD_A2    = 'h2AAA,
  parameter logic [7:0]     KEY1      = 8'hAA,
  parameter logic [7:0]     KEY2      = 8'h55,
  parameter logic [7:0]     OP_UNLOCK = 8'hA0,
  parameter logic [7:0]     OP_EXT    = 8'h80,
  parameter logic [7:0]     OP_ID_ON  = 8'h90,
  parameter logic [7:0]     OP_ID_OFF = 8'hF0,
  parameter logic [7:0]     OP_DIS    = 8'h20,
  parameter logic [7:0]     OP_ERASE  = 8'h10,
  parameter logic [7:0]     OP_LOCK   = 8'h40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          ld_vld,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  output wp_evt_e       evt
);
  wp_seq_e st_q, st_d;
  logic at1, hit1, hit2;

  assign at1  = (ld_addr == CMD_A1);
  assign hit1 = at1 && (ld_data == KEY1);
  assign hit2 = (ld_addr == CMD_A2) && (ld_data == KEY2);

  always_comb begin
    st_d = st_q;
    evt  = EV_NONE;
    if (ld_vld) begin
      st_d = SQ_IDLE;
      evt  = EV_DATA;
      if (enable) begin
        unique case (st_q)
          SQ_IDLE: if (hit1) begin st_d = SQ_K1; evt = EV_CMD; end
          SQ_K1:   if (hit2) begin st_d = SQ_K2; evt = EV_CMD; end
          SQ_K2: if (at1) begin
            if (ld_data == OP_UNLOCK)      evt = EV_UNLOCK;
            else if (ld_data == OP_EXT)    begin st_d = SQ_X0; evt = EV_CMD; end
            else if (ld_data == OP_ID_ON)  evt = EV_ID_ON;
            else if (ld_data == OP_ID_OFF) evt = EV_ID_OFF;
          end
          SQ_X0:   if (hit1) begin st_d = SQ_X1; evt = EV_CMD; end
          SQ_X1:   if (hit2) begin st_d = SQ_X2; evt = EV_CMD; end
          SQ_X2: if (at1) begin
            if (ld_data == OP_DIS)         evt = EV_DISABLE;
            else if (ld_data == OP_ERASE)  evt = EV_ERASE;
            else if (ld_data == OP_LOCK)   begin st_d = SQ_LK; evt = EV_CMD; end
          end
          SQ_LK:   evt = EV_LOCK;
          default: st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SQ_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/wp_cycle_ctrl.sv
module wp_cycle_ctrl
  import wp_pkg::*;
#(
  parameter int AW         = 19,
  parameter int BOOT_BYTES = 16384,
  parameter int LOAD_GAP   = 7500,
  parameter int PROG_CYC   = 500000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_vld,
  input  logic [AW-1:0] ld_addr,
  input  wp_evt_e       evt,
  output logic          rec_en,
  output logic          prog_go,
  output logic          prog_reject,
  output logic          erase_go,
  output logic          erase_reject,
  output logic          busy,
  output logic          prot_on,
  output logic          lock_lo,
  output logic          lock_hi,
  output logic          id_mode
);
  localparam int GW = $clog2(LOAD_GAP + 1);
  localparam int BW = $clog2(PROG_CYC + 1);
  localparam logic [GW-1:0] GAP_END  = GW'(LOAD_GAP - 1);
  localparam logic [BW-1:0] BUSY_END = BW'(PROG_CYC - 1);
  localparam logic [AW-1:0] LO_TOP   = AW'(BOOT_BYTES);
  localparam logic [AW-1:0] HI_BASE  = AW'((2 ** AW) - BOOT_BYTES);

  // persistent flags: configured clear, untouched by rst
  logic prot_q    = 1'b0;
  logic lock_lo_q = 1'b0;
  logic lock_hi_q = 1'b0;

  logic          win_open, win_data, win_unl, win_lo, win_hi;
  logic [GW-1:0] gap_cnt;
  logic [BW-1:0] bsy_cnt;
  logic          in_lo, in_hi, take;

  assign in_lo = (ld_addr < LO_TOP);
  assign in_hi = (ld_addr >= HI_BASE);
  assign take  = ld_vld && !busy;

  always_ff @(posedge clk) begin
    if (take) begin
      case (evt)
        EV_UNLOCK:  prot_q <= 1'b1;
        EV_DISABLE: prot_q <= 1'b0;
        EV_LOCK: begin
          if (in_lo) lock_lo_q <= 1'b1;
          if (in_hi) lock_hi_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open     <= 1'b0;
      win_data     <= 1'b0;
      win_unl      <= 1'b0;
      win_lo       <= 1'b0;
      win_hi       <= 1'b0;
      gap_cnt      <= '0;
      bsy_cnt      <= '0;
      busy         <= 1'b0;
      prog_go      <= 1'b0;
      prog_reject  <= 1'b0;
      erase_go     <= 1'b0;
      erase_reject <= 1'b0;
      id_mode      <= 1'b0;
    end else begin
      prog_go      <= 1'b0;
      prog_reject  <= 1'b0;
      erase_go     <= 1'b0;
      erase_reject <= 1'b0;
      if (busy) begin
        if (bsy_cnt == BUSY_END) busy <= 1'b0;
        else                     bsy_cnt <= bsy_cnt + 1'b1;
      end else if (take) begin
        win_open <= 1'b1;
        gap_cnt  <= '0;
        case (evt)
          EV_DATA: begin
            win_data <= 1'b1;
            if (in_lo) win_lo <= 1'b1;
            if (in_hi) win_hi <= 1'b1;
          end
          EV_UNLOCK, EV_DISABLE: win_unl <= 1'b1;
          EV_ID_ON:  id_mode <= 1'b1;
          EV_ID_OFF: id_mode <= 1'b0;
          EV_ERASE: begin
            if (lock_lo_q || lock_hi_q) erase_reject <= 1'b1;
            else                        erase_go     <= 1'b1;
            busy     <= 1'b1;
            bsy_cnt  <= '0;
            win_open <= 1'b0;
            win_data <= 1'b0;
            win_unl  <= 1'b0;
            win_lo   <= 1'b0;
            win_hi   <= 1'b0;
          end
          default: ;
        endcase
      end else if (win_open) begin
        if (gap_cnt == GAP_END) begin
          win_open <= 1'b0;
          win_data <= 1'b0;
          win_unl  <= 1'b0;
          win_lo   <= 1'b0;
          win_hi   <= 1'b0;
          gap_cnt  <= '0;
          if (win_data) begin
            busy    <= 1'b1;
            bsy_cnt <= '0;
            if ((prot_q && !win_unl) || (win_lo && lock_lo_q) || (win_hi && lock_hi_q))
              prog_reject <= 1'b1;
            else
              prog_go <= 1'b1;
          end
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
      end
    end
  end

  assign rec_en  = !win_data && !win_unl && !busy;
  assign prot_on = prot_q;
  assign lock_lo = lock_lo_q;
  assign lock_hi = lock_hi_q;
endmodule

// File: rtl/wp_id_reader.sv
module wp_id_reader #(
  parameter int AW     = 19,
  parameter int ID_OFS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_sel_n,
  input  logic          out_en_n,
  input  logic          wr_en_n,
  input  logic [AW-1:0] addr,
  input  logic          id_mode,
  input  logic          lock_lo,
  input  logic          lock_hi,
  output logic          id_valid,
  output logic [7:0]    id_data
);
  localparam logic [AW-1:0] LO_ID = AW'(ID_OFS);
  localparam logic [AW-1:0] HI_ID = AW'((2 ** AW) - 16 + ID_OFS);

  logic       rd_hit;
  logic [7:0] rd_val;

  assign rd_hit = !chip_sel_n && !out_en_n && wr_en_n && id_mode;

  always_comb begin
    if (addr == LO_ID)      rd_val = lock_lo ? 8'hFF : 8'hFE;
    else if (addr == HI_ID) rd_val = lock_hi ? 8'hFF : 8'hFE;
    else                    rd_val = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_valid <= 1'b0;
      id_data  <= 8'h00;
    end else begin
      id_valid <= rd_hit;
      id_data  <= rd_hit ? rd_val : 8'h00;
    end
  end
endmodule

// File: rtl/wp_cmd_sequencer.sv
module wp_cmd_sequencer
  import wp_pkg::*;
#(
  parameter int            AW         = 19,
  parameter int            MIN_PULSE  = 3,
  parameter int            PWR_DLY    = 250000,
  parameter int            LOAD_GAP   = 7500,
  parameter int            PROG_CYC   = 500000,
  parameter int            BOOT_BYTES = 16384,
  parameter logic [AW-1:0] CMD_A1     = 'h5555,
  parameter logic [AW-1:0] CMD_A2     = 'h2AAA,
  parameter logic [7:0]    KEY1       = 8'hAA,
  parameter logic [7:0]    KEY2       = 8'h55,
  parameter logic [7:0]    OP_UNLOCK  = 8'hA0,
  parameter logic [7:0]    OP_EXT     = 8'h80,
  parameter logic [7:0]    OP_ID_ON   = 8'h90,
  parameter logic [7:0]    OP_ID_OFF  = 8'hF0,
  parameter logic [7:0]    OP_DIS     = 8'h20,
  parameter logic [7:0]    OP_ERASE   = 8'h10,
  parameter logic [7:0]    OP_LOCK    = 8'h40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_good,
  input  logic          chip_sel_n,
  input  logic          out_en_n,
  input  logic          wr_en_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          prog_go,
  output logic          prog_reject,
  output logic          erase_go,
  output logic          erase_reject,
  output logic          busy,
  output logic          prot_on,
  output logic          lock_lo,
  output logic          lock_hi,
  output logic          id_mode,
  output logic          id_valid,
  output logic [7:0]    id_data
);
  logic          ld_vld;
  logic [AW-1:0] ld_addr;
  logic [7:0]    ld_data;
  logic          rec_en;
  wp_evt_e       evt;

  wp_strobe_filter #(.AW(AW), .MIN_PULSE(MIN_PULSE), .PWR_DLY(PWR_DLY)) u_filt (
    .clk(clk), .rst(rst), .supply_good(supply_good),
    .chip_sel_n(chip_sel_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
    .addr(addr), .wdata(wdata),
    .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  wp_cmd_recog #(
    .AW(AW), .CMD_A1(CMD_A1), .CMD_A2(CMD_A2), .KEY1(KEY1), .KEY2(KEY2),
    .OP_UNLOCK(OP_UNLOCK), .OP_EXT(OP_EXT), .OP_ID_ON(OP_ID_ON),
    .OP_ID_OFF(OP_ID_OFF), .OP_DIS(OP_DIS), .OP_ERASE(OP_ERASE), .OP_LOCK(OP_LOCK)
  ) u_recog (
    .clk(clk), .rst(rst), .enable(rec_en),
    .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data), .evt(evt)
  );

  wp_cycle_ctrl #(
    .AW(AW), .BOOT_BYTES(BOOT_BYTES), .LOAD_GAP(LOAD_GAP), .PROG_CYC(PROG_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .ld_vld(ld_vld), .ld_addr(ld_addr), .evt(evt),
    .rec_en(rec_en), .prog_go(prog_go), .prog_reject(prog_reject),
    .erase_go(erase_go), .erase_reject(erase_reject), .busy(busy),
    .prot_on(prot_on), .lock_lo(lock_lo), .lock_hi(lock_hi), .id_mode(id_mode)
  );

  wp_id_reader #(.AW(AW), .ID_OFS(2)) u_idrd (
    .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .addr(addr), .id_mode(id_mode),
    .lock_lo(lock_lo), .lock_hi(lock_hi),
    .id_valid(id_valid), .id_data(id_data)
  );
endmodule

// File: rtl/wp_cmd_sequencer_chk.sv
module wp_cmd_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic prog_go,
  input logic prog_reject,
  input logic erase_go,
  input logic erase_reject,
  input logic busy,
  input logic lock_lo,
  input logic lock_hi,
  input logic id_mode,
  input logic id_valid
);
  a_r4_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_go, prog_reject, erase_go, erase_reject}));

  a_r6_busy_follows: assert property (@(posedge clk) disable iff (rst)
    (prog_go || prog_reject) |-> busy);

  a_r12_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !(prog_go || prog_reject || erase_go || erase_reject));

  a_r9_lock_lo_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_lo |=> lock_lo);

  a_r9_lock_hi_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_hi |=> lock_hi);

  a_r10_erase_needs_free: assert property (@(posedge clk) disable iff (rst)
    erase_go |-> !(lock_lo || lock_hi));

  a_r11_id_needs_mode: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> $past(id_mode));
endmodule

bind wp_cmd_sequencer wp_cmd_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .prog_go(prog_go), .prog_reject(prog_reject),
  .erase_go(erase_go), .erase_reject(erase_reject), .busy(busy),
  .lock_lo(lock_lo), .lock_hi(lock_hi), .id_mode(id_mode), .id_valid(id_valid)
);

// File: tb/wp_cmd_sequencer_bench.sv
module wp_cmd_sequencer_bench;
  localparam int AW = 19;
  localparam int MINP = 3;
  localparam int PWRD = 40;
  localparam int GAP = 16;
  localparam int PCYC = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_good = 1'b0;
  logic chip_sel_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic prog_go, prog_reject, erase_go, erase_reject, busy;
  logic prot_on, lock_lo, lock_hi, id_mode, id_valid;
  logic [7:0] id_data;

  int nchk = 0, nerr = 0;
  int n_go = 0, n_rej = 0, n_ego = 0, n_erej = 0, n_busy = 0;

  always #10 clk = ~clk;

  wp_cmd_sequencer #(.AW(AW), .MIN_PULSE(MINP), .PWR_DLY(PWRD),
                     .LOAD_GAP(GAP), .PROG_CYC(PCYC)) u_wp_cmd_sequencer (
    .clk(clk), .rst(rst), .supply_good(supply_good), .chip_sel_n(chip_sel_n),
    .out_en_n(out_en_n), .wr_en_n(wr_en_n), .addr(addr), .wdata(wdata),
    .prog_go(prog_go), .prog_reject(prog_reject), .erase_go(erase_go),
    .erase_reject(erase_reject), .busy(busy), .prot_on(prot_on),
    .lock_lo(lock_lo), .lock_hi(lock_hi), .id_mode(id_mode),
    .id_valid(id_valid), .id_data(id_data)
  );

  always @(negedge clk) begin
    if (prog_go) n_go++;
    if (prog_reject) n_rej++;
    if (erase_go) n_ego++;
    if (erase_reject) n_erej++;
    if (busy) n_busy++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [AW-1:0] a, input logic [7:0] d,
                          input int len, input logic oe_low);
    @(negedge clk);
    chip_sel_n = 1'b0; wr_en_n = 1'b0; out_en_n = !oe_low; addr = a; wdata = d;
    repeat (len) @(negedge clk);
    wr_en_n = 1'b1; chip_sel_n = 1'b1; out_en_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wb(input logic [AW-1:0] a, input logic [7:0] d);
    put_byte(a, d, MINP, 1'b0);
  endtask

  task automatic cmd3(input logic [7:0] op);
    wb(19'h05555, 8'hAA); wb(19'h02AAA, 8'h55); wb(19'h05555, op);
  endtask

  task automatic cmd6(input logic [7:0] op);
    cmd3(8'h80); wb(19'h05555, 8'hAA); wb(19'h02AAA, 8'h55); wb(19'h05555, op);
  endtask

  task automatic settle();
    repeat (GAP + PCYC + 8) @(negedge clk);
  endtask

  task automatic id_read(input logic [AW-1:0] a, output logic v, output logic [7:0] d);
    @(negedge clk);
    chip_sel_n = 1'b0; out_en_n = 1'b0; wr_en_n = 1'b1; addr = a;
    @(negedge clk);
    v = id_valid; d = id_data;
    chip_sel_n = 1'b1; out_en_n = 1'b1;
  endtask

  task automatic outcome(input string req, input int g0, input int r0,
                         input int eg, input int er);
    chk({req, " go count"}, n_go - g0, eg);
    chk({req, " reject count"}, n_rej - r0, er);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int g, r, b, e1, e2;
    logic v;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // reset state (R5: protection off after configuration)
    chk("R5 reset busy", busy, 0);
    chk("R5 reset prot_on", prot_on, 0);
    chk("R9 reset locks", lock_lo + lock_hi, 0);
    chk("R11 reset id_valid", id_valid, 0);
    @(negedge clk); rst = 1'b0;

    // R1: supply hold-off
    supply_good = 1'b1;
    g = n_go; r = n_rej;
    wb(19'h40000, 8'h11); settle();
    outcome("R1 early write", g, r, 0, 0);
    repeat (PWRD + 5) @(negedge clk);
    g = n_go; r = n_rej;
    wb(19'h40000, 8'h12); settle();
    outcome("R1 after hold-off", g, r, 1, 0);
    supply_good = 1'b0; @(negedge clk); supply_good = 1'b1;
    g = n_go; r = n_rej;
    wb(19'h40000, 8'h13); settle();
    outcome("R1 after supply drop", g, r, 0, 0);
    repeat (PWRD + 5) @(negedge clk);

    // R2: strobe filter and read-enable inhibit
    g = n_go; r = n_rej;
    put_byte(19'h40001, 8'h21, MINP - 1, 1'b0); settle();
    outcome("R2 short strobe", g, r, 0, 0);
    g = n_go;
    put_byte(19'h40001, 8'h22, MINP, 1'b0); settle();
    chk("R2 min strobe go", n_go - g, 1);
    g = n_go; r = n_rej;
    put_byte(19'h40001, 8'h23, MINP + 2, 1'b1); settle();
    outcome("R2 oe low inhibit", g, r, 0, 0);

    // R4 and R6: multi-byte window, one outcome, busy length
    g = n_go; r = n_rej; b = n_busy;
    wb(19'h40010, 8'h01); wb(19'h40011, 8'h02); wb(19'h40012, 8'h03);
    settle();
    outcome("R4 multi-byte window", g, r, 1, 0);
    chk("R6 busy length", n_busy - b, PCYC);

    // R10: erase while unlocked
    e1 = n_ego; e2 = n_erej;
    cmd6(8'h10); settle();
    chk("R10 erase go", n_ego - e1, 1);
    chk("R10 erase reject none", n_erej - e2, 0);

    // R11: identification mode
    cmd3(8'h90); settle();
    chk("R11 id_mode on", id_mode, 1);
    id_read(19'h00002, v, d);
    chk("R11 low id valid", v, 1);
    chk("R11 low id FE", d, 8'hFE);
    id_read(19'h7FFF2, v, d);
    chk("R11 high id FE", d, 8'hFE);
    id_read(19'h00005, v, d);
    chk("R11 other addr 00", d, 8'h00);
    cmd3(8'hF0); settle();
    id_read(19'h00002, v, d);
    chk("R11 exit id_valid", v, 0);

    // R3: address from first clock, data from last clock
    @(negedge clk);
    chip_sel_n = 1'b0; wr_en_n = 1'b0; addr = 19'h05555; wdata = 8'h00;
    @(negedge clk); addr = 19'h00000;
    @(negedge clk); wdata = 8'hAA;
    @(negedge clk); wr_en_n = 1'b1; chip_sel_n = 1'b1;
    repeat (2) @(negedge clk);
    wb(19'h02AAA, 8'h55); wb(19'h05555, 8'h90); settle();
    chk("R3 skewed strobe decoded", id_mode, 1);
    cmd3(8'hF0); settle();

    // R5: enable with prefix
    g = n_go; r = n_rej;
    cmd3(8'hA0); wb(19'h40020, 8'h31); settle();
    outcome("R5 prefix window", g, r, 1, 0);
    chk("R5 prot_on set", prot_on, 1);
    @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    chk("R5 prot survives rst", prot_on, 1);
    repeat (PWRD + 5) @(negedge clk);

    // R6: protected, no prefix
    g = n_go; r = n_rej; b = n_busy;
    wb(19'h40021, 8'h32); settle();
    outcome("R6 unprefixed", g, r, 0, 1);
    chk("R6 dummy busy length", n_busy - b, PCYC);

    // R8: broken sequence while protected
    g = n_go; r = n_rej;
    wb(19'h05555, 8'hAA); wb(19'h02AAA, 8'h56); wb(19'h05555, 8'hA0); settle();
    outcome("R8 broken prefix", g, r, 0, 1);

    // R5: prefix again
    g = n_go; r = n_rej;
    cmd3(8'hA0); wb(19'h40022, 8'h33); settle();
    outcome("R5 second prefix", g, r, 1, 0);

    // R7: disable then data
    g = n_go; r = n_rej;
    cmd6(8'h20); wb(19'h40023, 8'h34); settle();
    outcome("R7 disable window", g, r, 1, 0);
    chk("R7 prot_on cleared", prot_on, 0);
    g = n_go; r = n_rej;
    wb(19'h40024, 8'h35); settle();
    outcome("R7 plain after disable", g, r, 1, 0);

    // R8: wrong third byte counts as data when unprotected
    g = n_go; r = n_rej;
    cmd3(8'h91); settle();
    outcome("R8 wrong opcode is data", g, r, 1, 0);
    chk("R8 prot unchanged", prot_on, 0);

    // R9: low region lock
    cmd6(8'h40); wb(19'h00100, 8'h00); settle();
    chk("R9 lock_lo set", lock_lo, 1);
    chk("R9 lock_hi clear", lock_hi, 0);
    cmd3(8'h90); settle();
    id_read(19'h00002, v, d);
    chk("R9 low id FF", d, 8'hFF);
    id_read(19'h7FFF2, v, d);
    chk("R9 high id FE", d, 8'hFE);
    cmd3(8'hF0); settle();
    g = n_go; r = n_rej;
    wb(19'h00100, 8'h41); settle();
    outcome("R9 write locked low", g, r, 0, 1);
    g = n_go; r = n_rej;
    wb(19'h7FF00, 8'h42); settle();
    outcome("R9 write open high", g, r, 1, 0);

    // R10: erase refused
    e1 = n_ego; e2 = n_erej;
    cmd6(8'h10); settle();
    chk("R10 erase go none", n_ego - e1, 0);
    chk("R10 erase reject", n_erej - e2, 1);

    // R9: high region lock
    cmd6(8'h40); wb(19'h7FF00, 8'h00); settle();
    chk("R9 lock_hi set", lock_hi, 1);
    g = n_go; r = n_rej;
    wb(19'h7FF00, 8'h43); settle();
    outcome("R9 write locked high", g, r, 0, 1);

    // R12: load during busy ignored
    g = n_go; r = n_rej;
    wb(19'h40030, 8'h51);
    for (int i = 0; i < GAP + 10 && !busy; i++) @(negedge clk);
    wb(19'h40031, 8'h52);
    settle();
    outcome("R12 load during busy", g, r, 1, 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule